// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block shapes programmed-I/O read and write cycles for a two-channel ATA host that serves four drive slots: slots 0 and 1 sit on the primary channel, and slots 2 and 3 sit on the secondary channel. A host request names a slot and a direction. It can also mark the access as a command-block access. The block then runs three phases in order. In the setup phase the channel select and drive select are driven and stable. In the active phase the read or write strobe is asserted. In the recovery phase the strobe is released and the selects are still held. At the end of recovery the block pulses `done`.

Timing comes from a small register file. Each timing set has a setup register holding a 2-bit code and a pulse byte holding the active and recovery counts. The primary slots each have their own set. The two secondary slots share one set. Command-block accesses draw their pulse byte from a separate command register.

The chip revision input changes how long recovery lasts. Revision 0 is treated as invalid: while it is present, requests are refused and an error flag is raised.

Top module: `ata_pio_sequencer`

## Requirements
- R1: A setup register keeps only bits 7:6 as the setup code. Bits 5:0 of a write are discarded and always read back as 0. The code maps to setup clocks as follows: 00 gives 4, 10 gives 3, 01 gives 2, 11 gives 5.
- R2: In a pulse byte, bits 7:4 hold the active count and bits 3:0 hold the recovery count. A nibble of 0 stands for 16 clocks.
- R3: An active nibble of 1 produces a strobe 2 clocks wide. No strobe is ever narrower than 2 clocks.
- R4: If the active count is above 3 and the recovery nibble is 1, recovery lasts 2 clocks. If the active count is 3 or less, a recovery nibble of 1 stays at 1 clock.
- R5: When chip_rev is 2 or 3, recovery lasts one clock longer than the count from R2 and R4.
- R6: The register map is: address 0 = slot 0 setup, 1 = slot 0 pulse, 2 = slot 1 setup, 3 = slot 1 pulse, 4 = secondary setup, 5 = secondary pulse, 6 = command pulse. Address 7 reads 0 and ignores writes. Slots 2 and 3 both use addresses 4 and 5.
- R7: When req_cmd is 1, the active and recovery counts come from the command pulse register, with the same rules as R2 to R5. The setup code still comes from the slot's own set. A command pulse of 0 gives 16/16.
- R8: After reset every register reads 0. An access made with no register written therefore takes 4 setup, 16 active and 16 recovery clocks.
- R9: cs_pri is high for slots 0 and 1 and cs_sec for slots 2 and 3. dev_sel equals bit 0 of the slot. All three hold from the first setup clock through the last recovery clock. Exactly one strobe is high, and only during the active phase: wr_stb if req_write is 1, otherwise rd_stb.
- R10: done is high for exactly the last recovery clock. A request present at the end of that clock is accepted at once and begins setup on the next clock. A request raised while a cycle is in progress, and dropped before done, is ignored.
- R11: While chip_rev is 0, no request is accepted. err follows (chip_rev == 0) with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address (map in R6) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| chip_rev | input | 2 | Chip revision; 0 is invalid |
| req_valid | input | 1 | Access request |
| req_slot | input | 2 | Target drive slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 1 | 1 = command-block access |
| cs_pri | output | 1 | Primary channel select |
| cs_sec | output | 1 | Secondary channel select |
| dev_sel | output | 1 | Drive select within the channel |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | Last recovery clock of a cycle |
| err | output | 1 | Invalid revision flag |

## Verification
Two events can fall in the same clock: the last recovery clock with its `done` pulse, and the acceptance of the next request. The bench provokes this by chaining accesses. It raises a new request during the `done` clock, often for a different slot. It then checks three things: the selects switch straight to the new slot with no idle clock, the new cycle's setup count is complete, and no strobe leaks across the boundary. In a separate directed case, a request is raised and dropped in the middle of a cycle. The bench confirms that this request is ignored by checking that the selects fall to idle after `done`.

// File: rtl/pio_timing_pkg.sv
// pio_timing_pkg
// Shared widths, phase type and count decoders for the PIO timing sequencer.
// Assumes counts never exceed 17 clocks, so CNT_W = 5 is sufficient.
package pio_timing_pkg;

    localparam int CNT_W    = 5;
    localparam int NIB_W    = 4;
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int CODE_W   = 2;
    localparam int SET_NUM  = 3;            // primary 0, primary 1, secondary
    localparam int ADDR_W   = 3;
    localparam int REV_W    = 2;
    localparam int SLOT_W   = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } counts_t;

    // Non-monotonic setup code to clock count.
    function automatic logic [CNT_W-1:0] setup_clocks(input logic [CODE_W-1:0] code);
        case (code)
            2'b00:   setup_clocks = CNT_W'(4);
            2'b10:   setup_clocks = CNT_W'(3);
            2'b01:   setup_clocks = CNT_W'(2);
            default: setup_clocks = CNT_W'(5);
        endcase
    endfunction

    // Nibble to clock count, zero standing for the full 16.
    function automatic logic [CNT_W-1:0] nib_clocks(input logic [NIB_W-1:0] nib);
        if (nib == '0)
            nib_clocks = CNT_W'(16);
        else
            nib_clocks = CNT_W'(nib);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
// pio_timing_regs
// Register file holding one setup code and one pulse byte per timing set,
// plus the command pulse byte. Only bits 7:6 of setup registers are stored.
// Assumes single-cycle writes; readback is combinational on the address.
module pio_timing_regs
    import pio_timing_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [BYTE_W-1:0]             rdata,
    output logic [SET_NUM-1:0][CODE_W-1:0] su_code,
    output logic [SET_NUM-1:0][BYTE_W-1:0] pulse,
    output logic [BYTE_W-1:0]             cmd_pulse
);

    localparam int IDX_W   = ADDR_W - 1;
    localparam int CMD_IDX = SET_NUM;

    logic [IDX_W-1:0] idx;
    logic             odd;

    assign idx = addr[ADDR_W-1:1];
    assign odd = addr[0];

    // Per-set storage, one generate branch per timing set.
    for (genvar g = 0; g < SET_NUM; g++) begin : g_set
        // Capture setup code (upper two bits only) or pulse byte for set g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                su_code[g] <= '0;
                pulse[g]   <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                if (odd)
                    pulse[g] <= wdata;
                else
                    su_code[g] <= wdata[BYTE_W-1 -: CODE_W];
            end
        end
    end

    // Capture the command pulse byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_pulse <= '0;
        else if (we && idx == IDX_W'(CMD_IDX) && !odd)
            cmd_pulse <= wdata;
    end

    // Readback multiplexer; setup registers read with zero low bits.
    always_comb begin
        rdata = '0;
        if (idx < IDX_W'(SET_NUM)) begin
            if (odd)
                rdata = pulse[idx];
            else
                rdata = {su_code[idx], {(BYTE_W-CODE_W){1'b0}}};
        end else if (!odd) begin
            rdata = cmd_pulse;
        end
    end

endmodule

// File: rtl/pio_timing_resolve.sv
// pio_timing_resolve
// Combinational selection of the timing set for a slot and conversion of
// the stored codes into effective setup, active and recovery clock counts.
// Assumes slot bit 1 selects the secondary channel.
module pio_timing_resolve
    import pio_timing_pkg::*;
(
    input  logic [SLOT_W-1:0]             slot,
    input  logic                          cmd,
    input  logic [REV_W-1:0]              rev,
    input  logic [SET_NUM-1:0][CODE_W-1:0] su_code,
    input  logic [SET_NUM-1:0][BYTE_W-1:0] pulse,
    input  logic [BYTE_W-1:0]             cmd_pulse,
    output counts_t                       counts
);

    localparam int SEC_SET = SET_NUM - 1;
    localparam logic [CNT_W-1:0] MIN_ACT = CNT_W'(2);
    localparam logic [CNT_W-1:0] MIN_REC = CNT_W'(2);
    localparam logic [CNT_W-1:0] LONG_ACT = CNT_W'(3);

    logic [1:0]        set_idx;
    logic [BYTE_W-1:0] pbyte;
    logic [CNT_W-1:0]  act_raw, rec_raw, act_eff, rec_fix;

    // Map slot to timing set: secondary slots share the last set.
    always_comb begin
        set_idx = slot[1] ? 2'(SEC_SET) : {1'b0, slot[0]};
    end

    // Pick the pulse byte: command timing or the set's own.
    always_comb begin
        pbyte = cmd ? cmd_pulse : pulse[set_idx];
    end

    // Decode nibbles and apply the active-floor and short-recovery rules.
    always_comb begin
        act_raw = nib_clocks(pbyte[BYTE_W-1 -: NIB_W]);
        rec_raw = nib_clocks(pbyte[NIB_W-1:0]);
        act_eff = (act_raw < MIN_ACT) ? MIN_ACT : act_raw;
        rec_fix = (act_eff > LONG_ACT && rec_raw == CNT_W'(1)) ? MIN_REC : rec_raw;
    end

    // Assemble the effective counts, adding a recovery clock on later revisions.
    always_comb begin
        counts.setup  = setup_clocks(su_code[set_idx]);
        counts.active = act_eff;
        counts.recov  = (rev > REV_W'(1)) ? rec_fix + CNT_W'(1) : rec_fix;
    end

endmodule

// File: rtl/pio_phase_engine.sv
// pio_phase_engine
// Three-phase cycle sequencer: setup, active, recovery. Latches the counts
// and target on acceptance, drives selects and strobes from its state, and
// flags the last recovery clock. Assumes every count is at least 1.
module pio_phase_engine
    import pio_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  counts_t           counts,
    input  logic [SLOT_W-1:0] slot,
    input  logic              write,
    output logic              ready,
    output logic              cs_pri,
    output logic              cs_sec,
    output logic              dev_sel,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              done
);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  act_q, rec_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wr_q;
    logic              last;

    assign last  = (cnt_q == CNT_W'(1));
    assign done  = (phase_q == PH_RECOV) && last;
    assign ready = (phase_q == PH_IDLE) || done;

    // Phase and counter progression, restarting on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (take) begin
            phase_q <= PH_SETUP;
            cnt_q   <= counts.setup;
        end else begin
            case (phase_q)
                PH_SETUP: begin
                    if (last) begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= act_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (last) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= rec_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Latch target and later-phase counts at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            rec_q  <= '0;
            slot_q <= '0;
            wr_q   <= 1'b0;
        end else if (take) begin
            act_q  <= counts.active;
            rec_q  <= counts.recov;
            slot_q <= slot;
            wr_q   <= write;
        end
    end

    // Select and strobe outputs decoded from the current phase.
    always_comb begin
        cs_pri  = (phase_q != PH_IDLE) && !slot_q[1];
        cs_sec  = (phase_q != PH_IDLE) &&  slot_q[1];
        dev_sel = (phase_q != PH_IDLE) &&  slot_q[0];
        rd_stb  = (phase_q == PH_ACTIVE) && !wr_q;
        wr_stb  = (phase_q == PH_ACTIVE) &&  wr_q;
    end

endmodule

// File: rtl/ata_pio_sequencer.sv
// ata_pio_sequencer
// Top level: register file, timing resolution and phase engine for PIO
// cycles on four drive slots over two channels. A request is accepted when
// the engine is idle or in its done clock and the revision is non-zero.
// Assumes the requester holds request fields stable while req_valid is high.
module ata_pio_sequencer
    import pio_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [1:0]        chip_rev,
    input  logic              req_valid,
    input  logic [1:0]        req_slot,
    input  logic              req_write,
    input  logic              req_cmd,
    output logic              cs_pri,
    output logic              cs_sec,
    output logic              dev_sel,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              done,
    output logic              err
);

    logic [SET_NUM-1:0][CODE_W-1:0] su_code;
    logic [SET_NUM-1:0][BYTE_W-1:0] pulse;
    logic [BYTE_W-1:0]              cmd_pulse;
    counts_t                        counts;
    logic                           ready, rev_ok, take, err_q;

    assign rev_ok = (chip_rev != '0);
    assign take   = req_valid && rev_ok && ready;
    assign err    = err_q;

    // Register the invalid-revision flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= !rev_ok;
    end

    pio_timing_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .su_code   (su_code),
        .pulse     (pulse),
        .cmd_pulse (cmd_pulse)
    );

    pio_timing_resolve u_resolve (
        .slot      (req_slot),
        .cmd       (req_cmd),
        .rev       (chip_rev),
        .su_code   (su_code),
        .pulse     (pulse),
        .cmd_pulse (cmd_pulse),
        .counts    (counts)
    );

    pio_phase_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .counts  (counts),
        .slot    (req_slot),
        .write   (req_write),
        .ready   (ready),
        .cs_pri  (cs_pri),
        .cs_sec  (cs_sec),
        .dev_sel (dev_sel),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .done    (done)
    );

endmodule

// File: rtl/pio_seq_checker.sv
// pio_seq_checker
// Port-level properties of the PIO sequencer, bound to the top module.
module pio_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chip_rev,
    input logic       cs_pri,
    input logic       cs_sec,
    input logic       dev_sel,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic       done
);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    assert_strobe_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> ((cs_pri || cs_sec) && $onehot0({cs_pri, cs_sec})));

    assert_select_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_pri || cs_sec) && !done) |=> ((cs_pri || cs_sec) && $stable(cs_pri) && $stable(dev_sel)));

    assert_done_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_stb && !wr_stb && (cs_pri || cs_sec)));

    assert_no_strobe_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!rd_stb && !wr_stb));

    assert_rd_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb) |-> $past(rd_stb, 2));

    assert_wr_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb) |-> $past(wr_stb, 2));

    assert_bad_rev_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rev == 2'd0 && !cs_pri && !cs_sec) |=> (!cs_pri && !cs_sec));

endmodule

bind ata_pio_sequencer pio_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_rev (chip_rev),
    .cs_pri   (cs_pri),
    .cs_sec   (cs_sec),
    .dev_sel  (dev_sel),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .done     (done)
);

// File: tb/sim_ata_pio_sequencer.sv
module sim_ata_pio_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [1:0] chip_rev = 2'd1;
    logic       req_valid = 1'b0;
    logic [1:0] req_slot = '0;
    logic       req_write = 1'b0;
    logic       req_cmd = 1'b0;
    logic       cs_pri, cs_sec, dev_sel, rd_stb, wr_stb, done, err;

    int n_chk = 0;
    int n_bad = 0;
    bit pending = 1'b0;

    logic [1:0] sh_su [3];
    logic [7:0] sh_pulse [3];
    logic [7:0] sh_cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chip_rev(chip_rev),
        .req_valid(req_valid), .req_slot(req_slot), .req_write(req_write),
        .req_cmd(req_cmd), .cs_pri(cs_pri), .cs_sec(cs_sec), .dev_sel(dev_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_setup(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b10: return 3;
            2'b01: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic int nib(input logic [3:0] n);
        return (n == 0) ? 16 : int'(n);
    endfunction

    function automatic int set_of(input logic [1:0] s);
        return s[1] ? 2 : int'(s[0]);
    endfunction

    task automatic exp_counts(input logic [1:0] s, input bit c,
                              output int es, output int ea, output int er);
        logic [7:0] p;
        p  = c ? sh_cmd : sh_pulse[set_of(s)];
        es = exp_setup(sh_su[set_of(s)]);
        ea = nib(p[7:4]);
        if (ea == 1) ea = 2;
        er = nib(p[3:0]);
        if (ea > 3 && er == 1) er = 2;
        if (chip_rev > 1) er = er + 1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 6) begin
            if (a[0]) sh_pulse[a[2:1]] = d;
            else      sh_su[a[2:1]] = d[7:6];
        end else if (a == 6) begin
            sh_cmd = d;
        end
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // One access; hold_next chains a new request into the done clock.
    task automatic access(input logic [1:0] s, input bit w, input bit c, input string tag,
                          input bit poke, input bit hold_next,
                          input logic [1:0] ns, input bit nw, input bit nc);
        int es, ea, er, su, ac, rc;
        bit seen_str, seen_done, cs_ok, typ_ok;
        exp_counts(s, c, es, ea, er);
        su = 0; ac = 0; rc = 0;
        seen_str = 0; seen_done = 0; cs_ok = 1; typ_ok = 1;
        if (!pending) begin
            @(negedge clk);
            req_valid = 1'b1; req_slot = s; req_write = w; req_cmd = c;
        end
        pending = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 64 && !seen_done; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 1) begin req_valid = 1'b1; req_slot = ~s; end
            if (poke && k == 2) req_valid = 1'b0;
            if (rd_stb || wr_stb) begin
                ac++; seen_str = 1;
                if (wr_stb != w || rd_stb != !w) typ_ok = 0;
            end else if (!seen_str) su++;
            else rc++;
            if (cs_pri != !s[1] || cs_sec != s[1] || dev_sel != s[0]) cs_ok = 0;
            if (done) begin
                seen_done = 1;
                if (hold_next) begin
                    req_valid = 1'b1; req_slot = ns; req_write = nw; req_cmd = nc;
                    pending = 1'b1;
                end
            end
        end
        chk(su == es, {tag, " R1 setup clocks"}, su, es);
        chk(ac == ea, {tag, " R3 active clocks"}, ac, ea);
        chk(rc == er, {tag, " R4 recovery clocks"}, rc, er);
        chk(cs_ok, {tag, " R9 selects"}, cs_ok, 1);
        chk(typ_ok, {tag, " R9 strobe kind"}, typ_ok, 1);
        chk(seen_done, {tag, " R10 done seen"}, seen_done, 1);
        if (!hold_next) begin
            @(negedge clk);
            chk(!cs_pri && !cs_sec && !done, {tag, " R10 idle after done"},
                {cs_pri, cs_sec, done}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5417));
        for (int i = 0; i < 3; i++) begin sh_su[i] = '0; sh_pulse[i] = '0; end
        sh_cmd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state and register defaults
        chk(!cs_pri && !cs_sec && !rd_stb && !wr_stb && !done && !err, "R8 outputs idle",
            {cs_pri, cs_sec, rd_stb, wr_stb, done, err}, 0);
        for (int a = 0; a < 8; a++) rd_reg(3'(a), 8'h00, "R8 reset readback");
        access(2'd0, 1'b0, 1'b0, "R8 default", 0, 0, 0, 0, 0);

        // R1: setup register keeps bits 7:6 only, each code decoded
        wr_reg(3'd0, 8'hFF);
        rd_reg(3'd0, 8'hC0, "R1 low bits dropped");
        wr_reg(3'd1, 8'h22);
        for (int c = 0; c < 4; c++) begin
            wr_reg(3'd0, {2'(c), 6'h15});
            access(2'd0, 1'b1, 1'b0, "R1 code", 0, 0, 0, 0, 0);
        end

        // R2/R3/R4: nibble rules at revision 1
        wr_reg(3'd3, 8'h15);
        access(2'd1, 1'b0, 1'b0, "R3 act1", 0, 0, 0, 0, 0);
        wr_reg(3'd3, 8'h41);
        access(2'd1, 1'b1, 1'b0, "R4 act4 rec1", 0, 0, 0, 0, 0);
        wr_reg(3'd3, 8'h31);
        access(2'd1, 1'b0, 1'b0, "R4 act3 rec1", 0, 0, 0, 0, 0);
        wr_reg(3'd3, 8'h00);
        access(2'd1, 1'b0, 1'b0, "R2 zero nibbles", 0, 0, 0, 0, 0);

        // R5: later revision lengthens recovery
        chip_rev = 2'd2;
        wr_reg(3'd3, 8'h31);
        access(2'd1, 1'b1, 1'b0, "R5 rev2", 0, 0, 0, 0, 0);
        chip_rev = 2'd1;

        // R6: secondary slots share one set
        wr_reg(3'd4, 8'h40);
        wr_reg(3'd5, 8'h53);
        rd_reg(3'd5, 8'h53, "R6 readback");
        access(2'd2, 1'b0, 1'b0, "R6 slot2", 0, 0, 0, 0, 0);
        access(2'd3, 1'b1, 1'b0, "R6 slot3", 0, 0, 0, 0, 0);

        // R7: command timing, including zero meaning slowest
        wr_reg(3'd6, 8'h24);
        access(2'd0, 1'b0, 1'b1, "R7 cmd", 0, 0, 0, 0, 0);
        wr_reg(3'd6, 8'h00);
        access(2'd3, 1'b1, 1'b1, "R7 cmd zero", 0, 0, 0, 0, 0);

        // R10: request while busy ignored; chained request taken in done clock
        access(2'd0, 1'b0, 1'b0, "R10 busy poke", 1, 0, 0, 0, 0);
        access(2'd1, 1'b0, 1'b0, "R10 chain a", 0, 1, 2'd2, 1'b1, 1'b0);
        access(2'd2, 1'b1, 1'b0, "R10 chain b", 0, 1, 2'd0, 1'b0, 1'b1);
        access(2'd0, 1'b0, 1'b1, "R10 chain c", 0, 0, 0, 0, 0);

        // R11: revision 0 refuses requests and raises err
        @(negedge clk);
        chip_rev = 2'd0;
        req_valid = 1'b1; req_slot = 2'd1;
        begin
            bit any_cs = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (cs_pri || cs_sec) any_cs = 1;
            end
            chk(!any_cs, "R11 no cycle at rev0", any_cs, 0);
            chk(err == 1'b1, "R11 err raised", err, 1);
        end
        req_valid = 1'b0;
        chip_rev = 2'd3;
        @(negedge clk);
        chk(err == 1'b0, "R11 err cleared", err, 0);

        // R2: random mix of registers, revisions, slots and chaining
        for (int i = 0; i < 80; i++) begin
            logic [1:0] s, ns;
            bit w, c, nw, nc, hold;
            if (!pending) begin
                logic [2:0] a;
                logic [7:0] d;
                a = 3'($urandom_range(0, 7));
                d = 8'($urandom);
                if ($urandom_range(0, 3) == 0) d[3:0] = 4'd1;
                if ($urandom_range(0, 3) == 0) d[7:4] = 4'($urandom_range(0, 1));
                wr_reg(a, d);
                chip_rev = 2'($urandom_range(1, 3));
                s = 2'($urandom); w = 1'($urandom); c = ($urandom_range(0, 4) == 0);
            end else begin
                s = req_slot; w = req_write; c = req_cmd;
            end
            hold = ($urandom_range(0, 2) == 0) && (i < 79);
            ns = 2'($urandom); nw = 1'($urandom); nc = ($urandom_range(0, 4) == 0);
            access(s, w, c, "R2 random", 0, hold, ns, nw, nc);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule